// File: doc/BRIEF.md
# Single-Parity-Check Forward-Backward Extrinsic Processor

This block serves one check row of a layered LDPC decoder. For each row it takes a stream of L temporary messages (signed log-likelihood ratios with two fractional bits). It returns, for every bit, the extrinsic message that the parity constraint implies from all the *other* bits in the row. The check is treated as a two-state trellis. A forward pass runs a pairwise check function through the inputs and pushes each forward metric, together with its input, onto a stack. A backward pass then pops the stack and combines the forward metric with a running backward metric. This yields the extrinsic values, which leave in descending bit order.

The pairwise check function works in sign-magnitude form. The output sign is the product of the operand signs. The output magnitude is the smaller operand magnitude, plus a small correction term from a four-level table, minus another. Two stack banks alternate between rows. While the backward pass drains one row, the forward pass can fill the next. The row degree comes with the first input beat, so it can change from row to row, up to a parameter limit.

Top module: `spc_fb_proc`

## Requirements
- R1: A metric of "+infinity" is the value 2^(W-1)-1. The forward metric starts at that value for index 0. The forward metric for index k+1 equals f(forward metric k, input k).
- R2: The backward metric for the highest index L-1 is +infinity. The backward metric for index k-1 equals f(backward metric k, input k). The extrinsic output for index k equals f(forward metric k, backward metric k), so input k never feeds output k.
- R3: The sign of f(a,b) is negative exactly when one operand is negative and the magnitude is non-zero; a zero result is positive. The magnitude is min(|a|,|b|) + g(|a|+|b|) - g(||a|-|b||), floored at zero. The input -2^(W-1) counts as magnitude 2^(W-1)-1.
- R4: The correction term g takes its argument in quarter units and returns quarter units: g(0)=3, g(1..3)=2, g(4..8)=1, g(9 or more)=0.
- R5: A row's L extrinsic values leave on consecutive cycles with out_valid high, in order L-1 down to 0. out_last is high on index 0 only.
- R6: in_deg is sampled on the first beat of a row only. A value below 2 counts as 2, and a value above MAX_DEG counts as MAX_DEG. On later beats of the row, in_deg has no effect.
- R7: Once a row is fully received, in_ready stays low until the backward pass takes that row. An input held during that time is not consumed.
- R8: The next row is accepted while the previous row's extrinsic values are still being emitted.
- R9: During reset, in_ready is high and out_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input message present |
| in_ready | output | 1 | Block accepts the input message this cycle |
| in_llr | input | W | Temporary message, signed, two fractional bits |
| in_deg | input | clog2(MAX_DEG+1) | Row degree, taken on the first beat of a row |
| out_valid | output | 1 | Extrinsic message present |
| out_llr | output | W | Extrinsic message, signed |
| out_last | output | 1 | Marks the extrinsic message of bit index 0 |

## Verification
The bench builds the block with W=8 and MAX_DEG=6. With that maximum, the three-bit degree field can encode 7, so the clamp above the maximum is reachable. A short maximum also makes a long row followed by a short one fill the spare stack bank before the backward pass is free. That produces the input stall and its release within a few cycles. Hand-worked rows cover the most negative input, a zero result from mixed signs, and the small-magnitude region where the correction table matters. Mixed-degree rows streamed back to back cover the overlap of the two passes.

// File: rtl/spc_pkg.sv
package spc_pkg;

    typedef enum logic {
        FWD_FILL = 1'b0,
        FWD_FULL = 1'b1
    } fwd_state_e;

    typedef enum logic {
        BWD_IDLE = 1'b0,
        BWD_RUN  = 1'b1
    } bwd_state_e;

    // correction term, argument and result both in quarter units
    function automatic logic [1:0] corr_quarter(input logic [31:0] x);
        if (x == 32'd0)       return 2'd3;
        else if (x <= 32'd3)  return 2'd2;
        else if (x <= 32'd8)  return 2'd1;
        else                  return 2'd0;
    endfunction

endpackage

// File: rtl/spc_boxplus.sv
module spc_boxplus #(
    parameter int W = 8
) (
    input  logic signed [W-1:0] a_i,
    input  logic signed [W-1:0] b_i,
    output logic signed [W-1:0] y_o
);
    import spc_pkg::*;

    localparam logic [W-1:0] MAXMAG = {1'b0, {(W-1){1'b1}}};

    logic [W-1:0] a_u, b_u, a_raw, b_raw, am, bm;
    logic [W-1:0] sum, diff, mn;
    logic [1:0]   gs, gd;
    logic [W:0]   tot, gd_ext;
    logic [W-1:0] mag;
    logic         neg;

    always_comb begin
        a_u   = a_i;
        b_u   = b_i;
        a_raw = a_i[W-1] ? (~a_u + 1'b1) : a_u;
        b_raw = b_i[W-1] ? (~b_u + 1'b1) : b_u;
        am    = (a_raw > MAXMAG) ? MAXMAG : a_raw;
        bm    = (b_raw > MAXMAG) ? MAXMAG : b_raw;
        sum   = am + bm;
        diff  = (am > bm) ? (am - bm) : (bm - am);
        mn    = (am < bm) ? am : bm;
        gs    = corr_quarter(32'(sum));
        gd    = corr_quarter(32'(diff));
        tot    = {1'b0, mn} + (W+1)'(gs);
        gd_ext = (W+1)'(gd);
        mag    = (tot > gd_ext) ? W'(tot - gd_ext) : '0;
        neg    = (a_i[W-1] ^ b_i[W-1]) && (mag != '0);
        y_o    = neg ? $signed(~mag + 1'b1) : $signed(mag);
    end

endmodule

// File: rtl/spc_stack.sv
module spc_stack #(
    parameter int W     = 8,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en_i,
    input  logic                wr_bank_i,
    input  logic [AW-1:0]       wr_addr_i,
    input  logic signed [W-1:0] wr_alpha_i,
    input  logic signed [W-1:0] wr_gamma_i,
    input  logic                rd_bank_i,
    input  logic [AW-1:0]       rd_addr_i,
    output logic signed [W-1:0] rd_alpha_o,
    output logic signed [W-1:0] rd_gamma_o
);

    logic signed [W-1:0] alpha_q [2][DEPTH];
    logic signed [W-1:0] alpha_d [2][DEPTH];
    logic signed [W-1:0] gamma_q [2][DEPTH];
    logic signed [W-1:0] gamma_d [2][DEPTH];

    always_comb begin
        alpha_d = alpha_q;
        gamma_d = gamma_q;
        if (wr_en_i) begin
            alpha_d[wr_bank_i][wr_addr_i] = wr_alpha_i;
            gamma_d[wr_bank_i][wr_addr_i] = wr_gamma_i;
        end
        rd_alpha_o = alpha_q[rd_bank_i][rd_addr_i];
        rd_gamma_o = gamma_q[rd_bank_i][rd_addr_i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alpha_q <= '{default: '0};
            gamma_q <= '{default: '0};
        end else begin
            alpha_q <= alpha_d;
            gamma_q <= gamma_d;
        end
    end

endmodule

// File: rtl/spc_fwd.sv
module spc_fwd #(
    parameter int W       = 8,
    parameter int MAX_DEG = 8,
    localparam int DW     = $clog2(MAX_DEG + 1),
    localparam int AW     = $clog2(MAX_DEG)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid_i,
    output logic                in_ready_o,
    input  logic signed [W-1:0] in_llr_i,
    input  logic [DW-1:0]       in_deg_i,
    input  logic                take_i,
    output logic                full_o,
    output logic                full_bank_o,
    output logic [DW-1:0]       full_len_o,
    output logic                wr_en_o,
    output logic                wr_bank_o,
    output logic [AW-1:0]       wr_addr_o,
    output logic signed [W-1:0] wr_alpha_o,
    output logic signed [W-1:0] wr_gamma_o
);
    import spc_pkg::*;

    localparam logic signed [W-1:0] INF     = {1'b0, {(W-1){1'b1}}};
    localparam logic [DW-1:0]       DEG_MIN = DW'(2);
    localparam logic [DW-1:0]       DEG_MAX = DW'(MAX_DEG);

    typedef struct packed {
        fwd_state_e          st;
        logic                bank;
        logic [DW-1:0]       idx;
        logic [DW-1:0]       len;
        logic signed [W-1:0] alpha;
    } fwd_s;

    fwd_s s_q, s_d;

    logic                fire;
    logic [DW-1:0]       deg_c, eff_len;
    logic signed [W-1:0] alpha_cur, alpha_nx;

    spc_boxplus #(.W(W)) u_fwd_unit (
        .a_i (alpha_cur),
        .b_i (in_llr_i),
        .y_o (alpha_nx)
    );

    always_comb begin
        s_d        = s_q;
        in_ready_o = (s_q.st == FWD_FILL);
        fire       = in_valid_i && in_ready_o;
        if (in_deg_i < DEG_MIN)      deg_c = DEG_MIN;
        else if (in_deg_i > DEG_MAX) deg_c = DEG_MAX;
        else                         deg_c = in_deg_i;
        eff_len    = (s_q.idx == '0) ? deg_c : s_q.len;
        alpha_cur  = (s_q.idx == '0) ? INF : s_q.alpha;

        wr_en_o    = fire;
        wr_bank_o  = s_q.bank;
        wr_addr_o  = AW'(s_q.idx);
        wr_alpha_o = alpha_cur;
        wr_gamma_o = in_llr_i;

        if (fire) begin
            s_d.alpha = alpha_nx;
            s_d.len   = eff_len;
            if (DW'(s_q.idx + 1'b1) == eff_len) begin
                s_d.st  = FWD_FULL;
                s_d.idx = '0;
            end else begin
                s_d.idx = DW'(s_q.idx + 1'b1);
            end
        end
        if (s_q.st == FWD_FULL && take_i) begin
            s_d.st   = FWD_FILL;
            s_d.bank = ~s_q.bank;
        end

        full_o      = (s_q.st == FWD_FULL);
        full_bank_o = s_q.bank;
        full_len_o  = s_q.len;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: FWD_FILL, bank: 1'b0, idx: '0, len: DEG_MIN, alpha: INF};
        end else begin
            s_q <= s_d;
        end
    end

    // R6: a finished row never reports a degree outside the legal range
    a_r6_len_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> (full_len_o >= DEG_MIN && full_len_o <= DEG_MAX));

    // R6: stack writes stay inside one bank
    a_r6_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (int'(wr_addr_o) < MAX_DEG));

    // R7: a finished row keeps the input closed until the backward pass takes it
    a_r7_row_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && !take_i) |=> (full_o && !in_ready_o));

endmodule

// File: rtl/spc_bwd.sv
module spc_bwd #(
    parameter int W       = 8,
    parameter int MAX_DEG = 8,
    localparam int DW     = $clog2(MAX_DEG + 1),
    localparam int AW     = $clog2(MAX_DEG)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                full_i,
    input  logic                full_bank_i,
    input  logic [DW-1:0]       full_len_i,
    output logic                take_o,
    output logic                rd_bank_o,
    output logic [AW-1:0]       rd_addr_o,
    input  logic signed [W-1:0] rd_alpha_i,
    input  logic signed [W-1:0] rd_gamma_i,
    output logic                out_valid_o,
    output logic signed [W-1:0] out_llr_o,
    output logic                out_last_o
);
    import spc_pkg::*;

    localparam logic signed [W-1:0] INF = {1'b0, {(W-1){1'b1}}};

    typedef struct packed {
        bwd_state_e          st;
        logic                bank;
        logic [DW-1:0]       k;
        logic signed [W-1:0] beta;
        logic                ov;
        logic signed [W-1:0] ollr;
        logic                olast;
    } bwd_s;

    bwd_s s_q, s_d;

    logic                running, at_end;
    logic signed [W-1:0] ext, beta_nx;

    spc_boxplus #(.W(W)) u_out_unit (
        .a_i (rd_alpha_i),
        .b_i (s_q.beta),
        .y_o (ext)
    );

    spc_boxplus #(.W(W)) u_bwd_unit (
        .a_i (s_q.beta),
        .b_i (rd_gamma_i),
        .y_o (beta_nx)
    );

    always_comb begin
        s_d       = s_q;
        rd_bank_o = s_q.bank;
        rd_addr_o = AW'(s_q.k);
        running   = (s_q.st == BWD_RUN);
        at_end    = running && (s_q.k == '0);
        take_o    = full_i && (!running || at_end);

        s_d.ov    = 1'b0;
        s_d.olast = 1'b0;
        if (running) begin
            s_d.ov    = 1'b1;
            s_d.ollr  = ext;
            s_d.olast = at_end;
            s_d.beta  = beta_nx;
            if (at_end) s_d.st = BWD_IDLE;
            else        s_d.k  = DW'(s_q.k - 1'b1);
        end
        if (take_o) begin
            s_d.st   = BWD_RUN;
            s_d.bank = full_bank_i;
            s_d.k    = DW'(full_len_i - 1'b1);
            s_d.beta = INF;
        end

        out_valid_o = s_q.ov;
        out_llr_o   = s_q.ollr;
        out_last_o  = s_q.olast;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: BWD_IDLE, bank: 1'b0, k: '0, beta: INF,
                     ov: 1'b0, ollr: '0, olast: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    // R5: a row's outputs are contiguous until its last one
    a_r5_burst: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_last_o) |=> out_valid_o);

    // R5: a new row starts only after the previous row closed or from idle
    a_r5_row_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> (!out_valid_o || out_last_o));

endmodule

// File: rtl/spc_fb_proc.sv
module spc_fb_proc #(
    parameter int W       = 8,
    parameter int MAX_DEG = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 in_valid,
    output logic                                 in_ready,
    input  logic signed [W-1:0]                  in_llr,
    input  logic [$clog2(MAX_DEG+1)-1:0]         in_deg,
    output logic                                 out_valid,
    output logic signed [W-1:0]                  out_llr,
    output logic                                 out_last
);

    localparam int DW = $clog2(MAX_DEG + 1);
    localparam int AW = $clog2(MAX_DEG);

    logic                take, full, full_bank;
    logic [DW-1:0]       full_len;
    logic                wr_en, wr_bank, rd_bank;
    logic [AW-1:0]       wr_addr, rd_addr;
    logic signed [W-1:0] wr_alpha, wr_gamma, rd_alpha, rd_gamma;

    spc_fwd #(.W(W), .MAX_DEG(MAX_DEG)) u_fwd (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid_i  (in_valid),
        .in_ready_o  (in_ready),
        .in_llr_i    (in_llr),
        .in_deg_i    (in_deg),
        .take_i      (take),
        .full_o      (full),
        .full_bank_o (full_bank),
        .full_len_o  (full_len),
        .wr_en_o     (wr_en),
        .wr_bank_o   (wr_bank),
        .wr_addr_o   (wr_addr),
        .wr_alpha_o  (wr_alpha),
        .wr_gamma_o  (wr_gamma)
    );

    spc_stack #(.W(W), .DEPTH(MAX_DEG)) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en),
        .wr_bank_i  (wr_bank),
        .wr_addr_i  (wr_addr),
        .wr_alpha_i (wr_alpha),
        .wr_gamma_i (wr_gamma),
        .rd_bank_i  (rd_bank),
        .rd_addr_i  (rd_addr),
        .rd_alpha_o (rd_alpha),
        .rd_gamma_o (rd_gamma)
    );

    spc_bwd #(.W(W), .MAX_DEG(MAX_DEG)) u_bwd (
        .clk         (clk),
        .rst_n       (rst_n),
        .full_i      (full),
        .full_bank_i (full_bank),
        .full_len_i  (full_len),
        .take_o      (take),
        .rd_bank_o   (rd_bank),
        .rd_addr_o   (rd_addr),
        .rd_alpha_i  (rd_alpha),
        .rd_gamma_i  (rd_gamma),
        .out_valid_o (out_valid),
        .out_llr_o   (out_llr),
        .out_last_o  (out_last)
    );

endmodule

// File: tb/spc_fb_proc_bench.sv
module spc_fb_proc_bench;

    localparam int W    = 8;
    localparam int MAXD = 6;
    localparam int DW   = $clog2(MAXD + 1);

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                in_valid = 1'b0;
    logic signed [W-1:0] in_llr = '0;
    logic [DW-1:0]       in_deg = '0;
    logic                in_ready, out_valid, out_last;
    logic signed [W-1:0] out_llr;

    always #4ns clk = ~clk;

    spc_fb_proc #(.W(W), .MAX_DEG(MAXD)) u_spc_fb_proc (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_llr    (in_llr),
        .in_deg    (in_deg),
        .out_valid (out_valid),
        .out_llr   (out_llr),
        .out_last  (out_last)
    );

    typedef struct {
        int    val;
        bit    last;
        string tag;
    } exp_t;

    exp_t        q[$];
    int          n_chk = 0;
    int          n_fail = 0;
    int          stall_seen = 0;
    int          overlap_seen = 0;
    bit          finished = 0;
    int unsigned seed = 32'h1234_5678;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    function automatic int gq(input int x);
        if (x == 0) return 3;
        if (x <= 3) return 2;
        if (x <= 8) return 1;
        return 0;
    endfunction

    function automatic int bp(input int a, input int b);
        int ma, mb, mn, r, d;
        ma = (a < 0) ? -a : a;
        mb = (b < 0) ? -b : b;
        if (ma > 127) ma = 127;
        if (mb > 127) mb = 127;
        mn = (ma < mb) ? ma : mb;
        d  = (ma > mb) ? ma - mb : mb - ma;
        r  = mn + gq(ma + mb) - gq(d);
        if (r < 0) r = 0;
        if (((a < 0) != (b < 0)) && r != 0) return -r;
        return r;
    endfunction

    function automatic int clampd(input int d);
        if (d < 2) return 2;
        if (d > MAXD) return MAXD;
        return d;
    endfunction

    function automatic int rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'(seed >> 16);
    endfunction

    task automatic push_exp(input int v, input bit last, input string tag);
        exp_t e;
        e.val = v; e.last = last; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic model_row(input int dfield, input int vals[MAXD], input string tag);
        int L, beta;
        int alpha[MAXD];
        L = clampd(dfield);
        alpha[0] = 127;
        for (int k = 0; k < L - 1; k++) alpha[k+1] = bp(alpha[k], vals[k]);
        beta = 127;
        for (int k = L - 1; k >= 0; k--) begin
            push_exp(bp(alpha[k], beta), (k == 0), tag);
            beta = bp(beta, vals[k]);
        end
    endtask

    task automatic drive_row(input int dfield, input int n, input int vals[MAXD]);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_llr   = W'(vals[i]);
            in_deg   = (i == 0) ? DW'(dfield) : DW'(dfield ^ 5);
            while (!in_ready) @(negedge clk);
            @(posedge clk);
            #1ns in_valid = 1'b0;
        end
    endtask

    task automatic send(input int dfield, input int vals[MAXD], input string tag);
        model_row(dfield, vals, tag);
        drive_row(dfield, clampd(dfield), vals);
    endtask

    task automatic send_hand(input int n, input int vals[MAXD], input int ex[MAXD],
                             input string tag);
        for (int i = 0; i < n; i++) push_exp(ex[i], (i == n - 1), tag);
        drive_row(n, n, vals);
    endtask

    // monitor: pops the scoreboard as extrinsic values appear
    always @(negedge clk) begin
        exp_t e;
        if (rst_n) begin
            if (in_valid && !in_ready) stall_seen++;
            if (out_valid && in_valid && in_ready) overlap_seen++;
            if (out_valid) begin
                if (q.size() == 0) begin
                    check(1'b0, "R5", "unexpected output", int'(out_llr), 0);
                end else begin
                    e = q.pop_front();
                    check(int'(out_llr) == e.val, e.tag, "extrinsic", int'(out_llr), e.val);
                    check(out_last == e.last, "R5", "last flag", int'(out_last), int'(e.last));
                end
            end
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        int v[MAXD];
        int ex[MAXD];
        int d;

        repeat (2) @(posedge clk);
        @(negedge clk);
        check(in_ready == 1'b1, "R9", "in_ready in reset", int'(in_ready), 1);
        check(out_valid == 1'b0, "R9", "out_valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;

        // R2: degree two swaps the inputs, index 1 leaves first
        v = '{5, -5, 0, 0, 0, 0};      ex = '{5, -5, 0, 0, 0, 0};
        send_hand(2, v, ex, "R2");
        // R3: most negative input is clamped in magnitude
        v = '{-128, 3, 0, 0, 0, 0};    ex = '{-122, 3, 0, 0, 0, 0};
        send_hand(2, v, ex, "R3");
        // R4: small magnitudes where the correction table matters
        v = '{2, 3, 4, 0, 0, 0};       ex = '{1, 1, 2, 0, 0, 0};
        send_hand(3, v, ex, "R4");
        // R3: a zero result from mixed signs carries a positive sign
        v = '{-2, 2, 5, 0, 0, 0};      ex = '{0, -1, 1, 0, 0, 0};
        send_hand(3, v, ex, "R3");

        // R6: degree field clamping
        v = '{7, -9, 0, 0, 0, 0};
        send(0, v, "R6");
        v = '{-1, 20, 0, 0, 0, 0};
        send(1, v, "R6");
        v = '{10, -3, 1, 6, -40, 2};
        send(7, v, "R6");

        // R7: long row then short rows back to back forces the input to wait
        v = '{3, 3, -4, 7, 1, -2};
        send(6, v, "R7");
        v = '{9, -1, 0, 0, 0, 0};
        send(2, v, "R7");
        v = '{-6, 4, 0, 0, 0, 0};
        send(2, v, "R7");

        // R1: mixed rows of varying degree
        for (int r = 0; r < 40; r++) begin
            d = 2 + (rnd() % 5);
            for (int i = 0; i < MAXD; i++) begin
                if (r % 2 == 0) v[i] = (rnd() % 256) - 128;
                else            v[i] = (rnd() % 17) - 8;
            end
            send(d, v, "R1");
        end

        for (int t = 0; t < 200 && q.size() != 0; t++) @(negedge clk);
        repeat (3) @(negedge clk);
        check(q.size() == 0, "R5", "outputs still owed", q.size(), 0);
        check(stall_seen > 0, "R7", "input stall cycles seen", stall_seen, 1);
        check(overlap_seen > 0, "R8", "input accepted during output", overlap_seen, 1);

        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d outputs pending", q.size(), 0);
            summary();
            $finish;
        end
    end

endmodule